// File: doc/BRIEF.md
# Compare Output Pin Control Unit

This block owns the single output-compare state bit of one timer channel. On every compare-match pulse from the timer it updates that bit according to a two-bit output-mode field and the active waveform style: plain (non-PWM), single-slope PWM, or dual-slope PWM. It also drives the pin. While the mode field is nonzero, the pin value comes from the compare bit. While the field is zero, the pin value comes from the general-purpose port data bit. The pin direction always follows the port direction bit.

The timer, its counter and its match comparator are outside this block. They supply the following one-cycle pulses and levels:
- a match pulse;
- a counter-bottom pulse;
- a count-direction level.

Software writes the mode field at any time. A new field first acts on the compare bit at the next match. In plain mode, a force strobe applies the configured action at once. The compare bit keeps its value while the field is zero, so it can be preset before the pin is handed over.

Top module: `ocu_pin_ctrl`

## Requirements
- R1: Reset (rst_n low at a clock edge) clears oc_bit to 0 and clears the latched mode used for bottom events to 00.
- R2: pin_out equals oc_bit whenever out_mode is nonzero and equals port_dout when out_mode is 00, for every wave_sel value, with no clock delay.
- R3: pin_oe always equals port_dir, whatever out_mode holds.
- R4: A match with out_mode 00 leaves oc_bit unchanged in every waveform style.
- R5: With wave_sel 00 or 11 (plain), a match updates oc_bit at that clock edge according to out_mode: 01 toggles it, 10 clears it, 11 sets it.
- R6: With wave_sel 01 (single-slope PWM), a match clears oc_bit for out_mode 10 and sets it for 11. Out_mode 01 is reserved and does nothing.
- R7: With wave_sel 01, a cnt_bottom pulse without a match sets oc_bit if the out_mode latched at the most recent match was 10, and clears it if that latched value was 11. Any other latched value leaves oc_bit unchanged, so a field written after the last match has no effect at bottom.
- R8: With wave_sel 10 (dual-slope PWM), a match with out_mode 10 clears oc_bit when cnt_up is 1 and sets it when cnt_up is 0. Out_mode 11 does the reverse, and 01 does nothing.
- R9: In plain mode, force_cmp applies the action of the current out_mode at the next clock edge. A force and a match in the same cycle apply that action once.
- R10: In PWM styles (wave_sel 01 or 10), force_cmp alone changes nothing.
- R11: In single-slope PWM, a match and a bottom pulse in the same cycle apply only the match action.
- R12: A value placed in oc_bit while out_mode is 00 is held and appears on pin_out in the same cycle that out_mode becomes nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_hit | input | 1 | One-cycle compare-match pulse |
| cnt_bottom | input | 1 | One-cycle pulse when the counter reaches its bottom value |
| cnt_up | input | 1 | Count direction, 1 = counting up |
| force_cmp | input | 1 | Force strobe, honoured in plain mode only |
| out_mode | input | 2 | Output-mode field |
| wave_sel | input | 2 | Waveform style: 00/11 plain, 01 single-slope PWM, 10 dual-slope PWM |
| port_dout | input | 1 | General-purpose port data bit |
| port_dir | input | 1 | Port direction bit, 1 = output |
| oc_bit | output | 1 | Internal compare-output state bit |
| pin_out | output | 1 | Value driven towards the pin |
| pin_oe | output | 1 | Pin output enable |

## Verification
Several pairs of events can coincide. One pair is a force strobe with a match in plain toggle mode; it must produce exactly one toggle, not two. Another pair is a match with a bottom pulse in single-slope PWM; the match action must win.

Directed cases put both events in one cycle and compare oc_bit one edge later with a value predicted by the bench. The random phase raises match, bottom and force independently, so such collisions also occur inside mixed traffic. A bench model built from the requirements judges every cycle.

// File: rtl/ocu_pkg.sv
// Package: shared encodings for the compare output pin control unit.
// Assumes a two-bit output-mode field and a two-bit waveform-style select.
package ocu_pkg;

    localparam int MODE_W = 2;
    localparam int WAVE_W = 2;

    // Waveform style codes
    localparam logic [WAVE_W-1:0] WAVE_PLAIN     = 2'b00;
    localparam logic [WAVE_W-1:0] WAVE_FAST      = 2'b01;
    localparam logic [WAVE_W-1:0] WAVE_DUAL      = 2'b10;
    localparam logic [WAVE_W-1:0] WAVE_PLAIN_ALT = 2'b11;

    // Output-mode field codes
    localparam logic [MODE_W-1:0] OM_OFF = 2'b00;
    localparam logic [MODE_W-1:0] OM_A   = 2'b01;
    localparam logic [MODE_W-1:0] OM_B   = 2'b10;
    localparam logic [MODE_W-1:0] OM_C   = 2'b11;

    // Action applied to the compare bit on an event
    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_SET  = 2'b01,
        ACT_CLR  = 2'b10,
        ACT_TGL  = 2'b11
    } act_e;

    // True for the PWM styles, where force strobes are ignored
    function automatic logic wave_is_pwm(input logic [WAVE_W-1:0] w);
        return (w == WAVE_FAST) || (w == WAVE_DUAL);
    endfunction

endpackage

// File: rtl/ocu_action_dec.sv
// Module: ocu_action_dec
// Translates the output-mode field into the action for a match event and
// the action for a counter-bottom event, per waveform style.
// Assumes: the match decode uses the live field; the bottom decode uses the
// field latched at the last match. Reserved codes decode to no action.
module ocu_action_dec
    import ocu_pkg::*;
(
    input  logic [MODE_W-1:0] mode_live,
    input  logic [MODE_W-1:0] mode_held,
    input  logic [WAVE_W-1:0] wave,
    input  logic              count_up,
    output act_e              hit_act,
    output act_e              bot_act
);

    // Match action: depends on style, live field and count direction
    always_comb begin
        hit_act = ACT_NONE;
        unique case (wave)
            WAVE_FAST: begin
                unique case (mode_live)
                    OM_B:    hit_act = ACT_CLR;
                    OM_C:    hit_act = ACT_SET;
                    default: hit_act = ACT_NONE;
                endcase
            end
            WAVE_DUAL: begin
                unique case (mode_live)
                    OM_B:    hit_act = count_up ? ACT_CLR : ACT_SET;
                    OM_C:    hit_act = count_up ? ACT_SET : ACT_CLR;
                    default: hit_act = ACT_NONE;
                endcase
            end
            default: begin
                unique case (mode_live)
                    OM_A:    hit_act = ACT_TGL;
                    OM_B:    hit_act = ACT_CLR;
                    OM_C:    hit_act = ACT_SET;
                    default: hit_act = ACT_NONE;
                endcase
            end
        endcase
    end

    // Bottom action: single-slope PWM only, from the latched field
    always_comb begin
        bot_act = ACT_NONE;
        if (wave == WAVE_FAST) begin
            unique case (mode_held)
                OM_B:    bot_act = ACT_SET;
                OM_C:    bot_act = ACT_CLR;
                default: bot_act = ACT_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ocu_event_sel.sv
// Module: ocu_event_sel
// Arbitrates between match, force and bottom events in one cycle and picks
// the single action to apply. Also tells the state block when to capture
// the live field.
// Assumes: match and an honoured force collapse into one action; match
// outranks bottom.
module ocu_event_sel
    import ocu_pkg::*;
(
    input  logic              hit,
    input  logic              force_req,
    input  logic              bottom,
    input  logic [WAVE_W-1:0] wave,
    input  act_e              hit_act,
    input  act_e              bot_act,
    output act_e              apply_act,
    output logic              capture
);

    logic force_ok;
    logic hit_like;

    // Force counts only outside the PWM styles
    always_comb force_ok = force_req & ~wave_is_pwm(wave);

    // A match or an honoured force share the live-field action
    always_comb hit_like = hit | force_ok;

    // Choose the one action for this cycle
    always_comb begin
        if (hit_like) begin
            apply_act = hit_act;
        end else if (bottom) begin
            apply_act = bot_act;
        end else begin
            apply_act = ACT_NONE;
        end
    end

    // Only a real match refreshes the field used at bottom
    always_comb capture = hit;

endmodule

// File: rtl/ocu_state.sv
// Module: ocu_state
// Holds the compare-output bit and the output-mode field latched at the
// most recent match.
// Assumes a synchronous active-low reset that clears both.
module ocu_state
    import ocu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  act_e              apply_act,
    input  logic              capture,
    input  logic [MODE_W-1:0] mode_live,
    output logic              oc_q,
    output logic [MODE_W-1:0] mode_held
);

    logic oc_d;

    // Next value of the compare bit for the chosen action
    always_comb begin
        unique case (apply_act)
            ACT_SET: oc_d = 1'b1;
            ACT_CLR: oc_d = 1'b0;
            ACT_TGL: oc_d = ~oc_q;
            default: oc_d = oc_q;
        endcase
    end

    // Compare bit register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oc_q <= 1'b0;
        end else begin
            oc_q <= oc_d;
        end
    end

    // Field latched at each match, used by later bottom events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_held <= OM_OFF;
        end else if (capture) begin
            mode_held <= mode_live;
        end
    end

endmodule

// File: rtl/ocu_pin_mux.sv
// Module: ocu_pin_mux
// Chooses the pin value source and passes the port direction through.
// Assumes the override depends only on the live output-mode field.
module ocu_pin_mux
    import ocu_pkg::*;
(
    input  logic [MODE_W-1:0] mode_live,
    input  logic              oc_q,
    input  logic              port_val,
    input  logic              port_oe,
    output logic              pad_val,
    output logic              pad_oe
);

    logic takeover;

    // Any nonzero field hands the pin to the compare bit
    always_comb takeover = |mode_live;

    // Pin value selection
    always_comb pad_val = takeover ? oc_q : port_val;

    // Direction stays with the port
    always_comb pad_oe = port_oe;

endmodule

// File: rtl/ocu_pin_ctrl.sv
// Module: ocu_pin_ctrl (top)
// Compare output pin control for one timer channel: updates the compare
// bit on match, bottom and force events, and drives the pin.
// Assumes event inputs are one-cycle pulses from the timer.
module ocu_pin_ctrl
    import ocu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_hit,
    input  logic              cnt_bottom,
    input  logic              cnt_up,
    input  logic              force_cmp,
    input  logic [MODE_W-1:0] out_mode,
    input  logic [WAVE_W-1:0] wave_sel,
    input  logic              port_dout,
    input  logic              port_dir,
    output logic              oc_bit,
    output logic              pin_out,
    output logic              pin_oe
);

    act_e              hit_act;
    act_e              bot_act;
    act_e              apply_act;
    logic              capture;
    logic [MODE_W-1:0] mode_held;

    ocu_action_dec u_dec (
        .mode_live (out_mode),
        .mode_held (mode_held),
        .wave      (wave_sel),
        .count_up  (cnt_up),
        .hit_act   (hit_act),
        .bot_act   (bot_act)
    );

    ocu_event_sel u_sel (
        .hit       (cmp_hit),
        .force_req (force_cmp),
        .bottom    (cnt_bottom),
        .wave      (wave_sel),
        .hit_act   (hit_act),
        .bot_act   (bot_act),
        .apply_act (apply_act),
        .capture   (capture)
    );

    ocu_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .apply_act (apply_act),
        .capture   (capture),
        .mode_live (out_mode),
        .oc_q      (oc_bit),
        .mode_held (mode_held)
    );

    ocu_pin_mux u_mux (
        .mode_live (out_mode),
        .oc_q      (oc_bit),
        .port_val  (port_dout),
        .port_oe   (port_dir),
        .pad_val   (pin_out),
        .pad_oe    (pin_oe)
    );

endmodule

// File: rtl/ocu_pin_ctrl_chk.sv
// Module: ocu_pin_ctrl_chk
// Assertion checker for ocu_pin_ctrl, attached by bind.
module ocu_pin_ctrl_chk
    import ocu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_hit,
    input logic              cnt_bottom,
    input logic              cnt_up,
    input logic              force_cmp,
    input logic [MODE_W-1:0] out_mode,
    input logic [WAVE_W-1:0] wave_sel,
    input logic              port_dout,
    input logic              port_dir,
    input logic              oc_bit,
    input logic              pin_out,
    input logic              pin_oe
);

    logic plain;
    assign plain = (wave_sel == WAVE_PLAIN) || (wave_sel == WAVE_PLAIN_ALT);

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (oc_bit == 1'b0)); // R1

    AST_PORT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == OM_OFF) |-> (pin_out == port_dout)); // R2

    AST_OVERRIDE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode != OM_OFF) |-> (pin_out == oc_bit)); // R2

    AST_DIR_FROM_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode != OM_OFF) |-> (pin_oe == port_dir)); // R3

    AST_OFF_MATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_hit && out_mode == OM_OFF && wave_sel != WAVE_FAST) |=> $stable(oc_bit)); // R4

    AST_PLAIN_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (plain && (cmp_hit || force_cmp) && out_mode == OM_A) |=> (oc_bit != $past(oc_bit))); // R9

    AST_PLAIN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (plain && cmp_hit && out_mode == OM_C) |=> oc_bit); // R5

    AST_FAST_HIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_sel == WAVE_FAST && cmp_hit && cnt_bottom && out_mode == OM_B) |=> !oc_bit); // R11

    AST_PWM_FORCE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!plain && force_cmp && !cmp_hit && !cnt_bottom) |=> $stable(oc_bit)); // R10

    AST_DUAL_DOWN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_sel == WAVE_DUAL && cmp_hit && !cnt_up && out_mode == OM_B) |=> oc_bit); // R8

endmodule

bind ocu_pin_ctrl ocu_pin_ctrl_chk u_chk (.*);

// File: tb/sim_ocu_pin_ctrl.sv
`timescale 1ns/1ps
module sim_ocu_pin_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmp_hit, cnt_bottom, cnt_up, force_cmp;
    logic [1:0] out_mode, wave_sel;
    logic       port_dout, port_dir;
    logic       oc_bit, pin_out, pin_oe;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_cnt = 0;
    logic m_oc = 1'b0;
    logic [1:0] m_held = 2'b00;

    always #4 clk = ~clk;

    ocu_pin_ctrl u0 (.*);

    // Action for a match: 0 none, 1 set, 2 clear, 3 toggle
    function automatic logic [1:0] hit_code(input logic [1:0] m, input logic [1:0] w, input logic up);
        if (m == 2'b00) return 2'd0;
        if (w == 2'b01) return (m == 2'b10) ? 2'd2 : (m == 2'b11) ? 2'd1 : 2'd0;
        if (w == 2'b10) begin
            if (m == 2'b10) return up ? 2'd2 : 2'd1;
            if (m == 2'b11) return up ? 2'd1 : 2'd2;
            return 2'd0;
        end
        return (m == 2'b01) ? 2'd3 : (m == 2'b10) ? 2'd2 : 2'd1;
    endfunction

    function automatic logic apply(input logic [1:0] c, input logic v);
        case (c)
            2'd1: return 1'b1;
            2'd2: return 1'b0;
            2'd3: return ~v;
            default: return v;
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, update model, compare at next negedge
    task automatic step(input string tag, input logic h, input logic b, input logic f,
                        input logic [1:0] m, input logic [1:0] w, input logic up,
                        input logic pd, input logic dir);
        logic plain;
        cmp_hit = h; cnt_bottom = b; force_cmp = f; out_mode = m;
        wave_sel = w; cnt_up = up; port_dout = pd; port_dir = dir;
        #1;
        check("R2 pin before edge", pin_out, (m != 2'b00) ? m_oc : pd);
        check("R3 direction", pin_oe, dir);
        plain = (w == 2'b00) || (w == 2'b11);
        if (h || (f && plain)) m_oc = apply(hit_code(m, w, up), m_oc);
        else if (b && w == 2'b01)
            m_oc = apply((m_held == 2'b10) ? 2'd1 : (m_held == 2'b11) ? 2'd2 : 2'd0, m_oc);
        if (h) m_held = m;
        @(negedge clk);
        check(tag, oc_bit, m_oc);
    endtask

    task automatic idle(input logic [1:0] m, input logic [1:0] w);
        step("R4 idle", 0, 0, 0, m, w, 1, 0, 1);
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        cmp_hit = 0; cnt_bottom = 0; force_cmp = 0; cnt_up = 1;
        out_mode = 2'b01; wave_sel = 2'b00; port_dout = 0; port_dir = 0;
        @(negedge clk);
        // Pulse a toggle-mode force while the reset is held
        force_cmp = 1;
        @(negedge clk);
        force_cmp = 0;
        check("R1 reset oc_bit", oc_bit, 1'b0);
        rst_n = 1'b1;
        m_oc = 0; m_held = 2'b00;

        // Directed: R1/R7, the bottom event after reset sees latched 00
        step("R7 bottom with latched 00 after reset (R1)", 0, 1, 0, 2'b10, 2'b01, 1, 0, 1);
        // Directed: R5 encodings
        step("R5 plain set", 1, 0, 0, 2'b11, 2'b00, 1, 0, 1);
        step("R5 plain toggle", 1, 0, 0, 2'b01, 2'b11, 1, 0, 1);
        step("R5 plain clear", 1, 0, 0, 2'b10, 2'b00, 1, 0, 1);
        // Directed: R9, a force in set mode applies at once
        step("R9 force set", 0, 0, 1, 2'b11, 2'b00, 1, 0, 1);
        // Directed: R4, a match with field 00 keeps the bit
        step("R4 field 00 match", 1, 0, 0, 2'b00, 2'b00, 1, 0, 1);
        // Directed: R12, the preset value appears when the field turns on
        out_mode = 2'b00; port_dout = 0; #1;
        check("R12 port while off", pin_out, 1'b0);
        out_mode = 2'b01; #1;
        check("R12 preset on pin", pin_out, 1'b1);
        // Directed: R9, force and match together give one toggle
        step("R9 force+match single toggle", 1, 0, 1, 2'b01, 2'b00, 1, 0, 1);
        // Directed: R10, force ignored in PWM styles
        step("R10 force fast", 0, 0, 1, 2'b11, 2'b01, 1, 0, 1);
        step("R10 force dual", 0, 0, 1, 2'b10, 2'b10, 0, 0, 1);
        // Directed: R6
        step("R6 fast match set", 1, 0, 0, 2'b11, 2'b01, 1, 0, 1);
        step("R6 fast reserved", 1, 0, 0, 2'b01, 2'b01, 1, 0, 1);
        step("R6 fast match clear", 1, 0, 0, 2'b10, 2'b01, 1, 0, 1);
        // Directed: R7, bottom uses the latched 10, not the new 11
        step("R7 bottom latched 10", 0, 1, 0, 2'b11, 2'b01, 1, 0, 1);
        // Directed: R11, the match outranks bottom
        step("R11 match+bottom", 1, 1, 0, 2'b10, 2'b01, 1, 0, 1);
        // Directed: R8
        step("R8 dual up 11", 1, 0, 0, 2'b11, 2'b10, 1, 0, 1);
        step("R8 dual up 10", 1, 0, 0, 2'b10, 2'b10, 1, 0, 1);
        step("R8 dual down 10", 1, 0, 0, 2'b10, 2'b10, 0, 0, 1);
        step("R8 dual down 11", 1, 0, 0, 2'b11, 2'b10, 0, 0, 1);
        idle(2'b11, 2'b10);

        // Random mix, with the tag picked by waveform style
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] w;
            string t;
            w = 2'($urandom_range(0, 3));
            t = (w == 2'b01) ? "R6 random fast" : (w == 2'b10) ? "R8 random dual" : "R5 random plain";
            step(t, ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
                 ($urandom_range(0, 5) == 0), 2'($urandom_range(0, 3)), w,
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc_cnt);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule